// File: doc/BRIEF.md
# Lockstep Shared Memory with Selectable Access Discipline

This block is a small register-based memory shared by several processor ports that all advance together. On every clock edge each port presents one step: a read, a write, or nothing. Reads in a step return the contents the memory held before that step. Writes from the step are applied at the same edge, so only reads in later steps see them.

A two-bit discipline input sets whether reads of the same address by several ports are allowed, and whether writes to the same address by several ports are allowed. A policy input picks how overlapping writes are settled when they are allowed. With the priority policy the lowest-numbered writer wins. With the agreement policy the value is stored only if every writer of that address supplies the same data. An access that the discipline rejects raises that port's violation flag. A rejected read returns zero. A rejected write is dropped. Read data and flags appear one cycle after the step.

Top module: `pram_mem_arbiter`

## Requirements
- R1: After reset every memory word reads as zero, and `rdata_o` and `viol_o` are all zero.
- R2: Port operation codes are 2'b00 idle, 2'b01 read, 2'b10 write and 2'b11 treated as idle. `mode_i` bit 1 set allows shared reads and bit 0 set allows shared writes. `wpol_i` 0 selects priority and 1 selects agreement. Results of a step are on `rdata_o`/`viol_o` in the next cycle.
- R3: A read returns the word as it was before the step. A write issued in the same step shows up only in reads of later steps.
- R4: With `mode_i[1]`=0, among ports reading one address only the lowest-numbered port gets data. The others raise `viol_o` and read zero.
- R5: With `mode_i[1]`=1, all ports reading one address get the same stored word and no violation.
- R6: With `mode_i[0]`=0, among ports writing one address only the lowest-numbered port's data is stored. The others raise `viol_o` and their data is dropped.
- R7: With `mode_i[0]`=1 and `wpol_i`=0, the lowest-numbered writer's data is stored and no writer is flagged.
- R8: With `mode_i[0]`=1 and `wpol_i`=1, agreeing writers store their common value without flags. If any two writers of the address disagree, nothing is stored there and every writer of it is flagged.
- R9: An idle port reads zero and never raises its violation flag.
- R10: Accesses to distinct addresses never conflict in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock |
| rst_n | input | 1 | Active-low reset, clears memory and outputs |
| mode_i | input | 2 | Access discipline: bit 1 shared read, bit 0 shared write |
| wpol_i | input | 1 | Shared-write policy: 0 priority, 1 agreement |
| op_i | input | 2*NP | Per-port operation, port p at bits [2p+1:2p] |
| addr_i | input | NP*AW | Per-port word address |
| wdata_i | input | NP*DW | Per-port write data |
| rdata_o | output | NP*DW | Per-port read data, one cycle after the step |
| viol_o | output | NP | Per-port rejection flag, aligned with read data |

## Verification
The bench aims at steps where several ports hit one address. A design that grants the wrong contender, or flags the winner, shows wrong data or flags on the lowest port. It runs a read and a write of the same word in one step. Forwarding the new value there would return it a step early. It sends disagreeing writers under the agreement policy: storing the lowest writer's value anyway would leave a changed word on readback. It also checks that the reserved operation code neither writes nor flags, and that rejected readers see zero rather than stale data.

// File: rtl/pram_pkg.sv
package pram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_RD   = 2'b01,
    OP_WR   = 2'b10,
    OP_RSV  = 2'b11
  } op_e;

  localparam int MODE_SHARED_RD_BIT = 1;
  localparam int MODE_SHARED_WR_BIT = 0;

  function automatic logic op_is_read(input logic [1:0] op);
    return op == OP_RD;
  endfunction

  function automatic logic op_is_write(input logic [1:0] op);
    return op == OP_WR;
  endfunction
endpackage

// File: rtl/pram_conflict.sv
module pram_conflict #(
  parameter int NP = 4,
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic [2*NP-1:0]  op_i,
  input  logic [NP*AW-1:0] addr_i,
  input  logic [NP*DW-1:0] wdata_i,
  output logic [NP-1:0]    rd_lower_o,   // a lower port reads the same word
  output logic [NP-1:0]    wr_lower_o,   // a lower port writes the same word
  output logic [NP-1:0]    wr_clash_o    // another writer of the word differs in data
);
  import pram_pkg::*;

  always_comb begin
    rd_lower_o = '0;
    wr_lower_o = '0;
    wr_clash_o = '0;
    for (int i = 0; i < NP; i++) begin
      for (int j = 0; j < NP; j++) begin
        if (j != i && addr_i[j*AW +: AW] == addr_i[i*AW +: AW]) begin
          if (j < i && op_is_read(op_i[2*j +: 2]) && op_is_read(op_i[2*i +: 2]))
            rd_lower_o[i] = 1'b1;
          if (op_is_write(op_i[2*j +: 2]) && op_is_write(op_i[2*i +: 2])) begin
            if (j < i) wr_lower_o[i] = 1'b1;
            if (wdata_i[j*DW +: DW] != wdata_i[i*DW +: DW]) wr_clash_o[i] = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pram_grant.sv
module pram_grant #(
  parameter int NP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*NP-1:0] op_i,
  input  logic [1:0]      mode_i,
  input  logic            wpol_i,
  input  logic [NP-1:0]   rd_lower_i,
  input  logic [NP-1:0]   wr_lower_i,
  input  logic [NP-1:0]   wr_clash_i,
  output logic [NP-1:0]   rd_ok_o,
  output logic [NP-1:0]   we_o,
  output logic [NP-1:0]   viol_o
);
  import pram_pkg::*;

  logic shared_rd, shared_wr;
  assign shared_rd = mode_i[MODE_SHARED_RD_BIT];
  assign shared_wr = mode_i[MODE_SHARED_WR_BIT];

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      logic rd, wr, wr_bad;
      rd = op_is_read(op_i[2*p +: 2]);
      wr = op_is_write(op_i[2*p +: 2]);
      rd_ok_o[p] = rd && (shared_rd || !rd_lower_i[p]);
      if (!shared_wr)  wr_bad = wr_lower_i[p];
      else if (wpol_i) wr_bad = wr_clash_i[p];
      else             wr_bad = 1'b0;
      we_o[p]   = wr && !wr_lower_i[p] && !wr_bad;
      viol_o[p] = (rd && !rd_ok_o[p]) || (wr && wr_bad);
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_chk
    p_excl_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_i[0] && op_i[2*p +: 2] == 2'b10 && !we_o[p]) |-> viol_o[p]);
    p_clash_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i[0] && wpol_i && wr_clash_i[p] && op_i[2*p +: 2] == 2'b10) |-> (!we_o[p] && viol_o[p]));
  end
endmodule

// File: rtl/pram_regfile.sv
module pram_regfile #(
  parameter int NP    = 4,
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    we_i,
  input  logic [NP*AW-1:0] addr_i,
  input  logic [NP*DW-1:0] wdata_i,
  output logic [NP*DW-1:0] rword_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_comb begin
    for (int p = 0; p < NP; p++)
      rword_o[p*DW +: DW] = mem_q[addr_i[p*AW +: AW]];
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_word
    logic [NP-1:0] hit;
    logic [DW-1:0] nxt;
    always_comb begin
      nxt = mem_q[e];
      for (int p = 0; p < NP; p++) begin
        hit[p] = we_i[p] && (addr_i[p*AW +: AW] == AW'(e));
        if (hit[p]) nxt = wdata_i[p*DW +: DW];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[e] <= '0;
      else        mem_q[e] <= nxt;
    end
    p_one_writer_r6: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit));
  end
endmodule

// File: rtl/pram_mem_arbiter.sv
module pram_mem_arbiter #(
  parameter int NP    = 4,
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             wpol_i,
  input  logic [2*NP-1:0]  op_i,
  input  logic [NP*AW-1:0] addr_i,
  input  logic [NP*DW-1:0] wdata_i,
  output logic [NP*DW-1:0] rdata_o,
  output logic [NP-1:0]    viol_o
);
  logic [NP-1:0]    rd_lower, wr_lower, wr_clash;
  logic [NP-1:0]    rd_ok, we, viol_now;
  logic [NP*DW-1:0] rword;
  logic [NP*DW-1:0] rdata_q;
  logic [NP-1:0]    viol_q;

  pram_conflict #(.NP(NP), .AW(AW), .DW(DW)) conflict_i (
    .op_i(op_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rd_lower_o(rd_lower), .wr_lower_o(wr_lower), .wr_clash_o(wr_clash));

  pram_grant #(.NP(NP)) grant_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .mode_i(mode_i), .wpol_i(wpol_i),
    .rd_lower_i(rd_lower), .wr_lower_i(wr_lower), .wr_clash_i(wr_clash),
    .rd_ok_o(rd_ok), .we_o(we), .viol_o(viol_now));

  pram_regfile #(.NP(NP), .DEPTH(DEPTH), .DW(DW)) regfile_i (
    .clk(clk), .rst_n(rst_n), .we_i(we), .addr_i(addr_i), .wdata_i(wdata_i),
    .rword_o(rword));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      viol_q  <= '0;
    end else begin
      for (int p = 0; p < NP; p++)
        rdata_q[p*DW +: DW] <= rd_ok[p] ? rword[p*DW +: DW] : '0;
      viol_q <= viol_now;
    end
  end

  assign rdata_o = rdata_q;
  assign viol_o  = viol_q;

  p_shared_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b11 && !wpol_i) |=> (viol_o == '0));

  for (genvar p = 0; p < NP; p++) begin : g_port
    p_reject_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i[2*p +: 2] == 2'b01 && !rd_ok[p]) |=> (rdata_o[p*DW +: DW] == '0 && viol_o[p]));
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i[2*p +: 2] == 2'b00 || op_i[2*p +: 2] == 2'b11) |=> (rdata_o[p*DW +: DW] == '0 && !viol_o[p]));
    for (genvar q = 0; q < p; q++) begin : g_pair
      p_excl_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i[1] && rd_ok[p] && rd_ok[q]) |-> (addr_i[p*AW +: AW] != addr_i[q*AW +: AW]));
    end
  end
endmodule

// File: tb/pram_mem_arbiter_tb.sv
module pram_mem_arbiter_tb_top;
  localparam int NP = 4, DEPTH = 16, DW = 8, AW = 4;

  typedef struct packed {
    logic [1:0]  mode;
    logic        pol;
    logic [7:0]  ops;
    logic [15:0] addrs;
    logic [31:0] wd;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 8'hAA, 16'h3210, 32'h44332211, 4'd10}, // R10 distinct writes
    '{2'd0, 1'b0, 8'h55, 16'h2222, 32'h0,        4'd4},  // R4 exclusive readers
    '{2'd2, 1'b0, 8'h55, 16'h2222, 32'h0,        4'd5},  // R5 shared readers
    '{2'd0, 1'b0, 8'h88, 16'h5050, 32'hBB00AA00, 4'd6},  // R6 exclusive writers
    '{2'd2, 1'b0, 8'h01, 16'h0005, 32'h0,        4'd6},  // R6 readback
    '{2'd3, 1'b0, 8'hAA, 16'h7777, 32'h44332211, 4'd7},  // R7 priority
    '{2'd2, 1'b0, 8'h01, 16'h0007, 32'h0,        4'd7},  // R7 readback
    '{2'd1, 1'b1, 8'h66, 16'h8888, 32'h005A005A, 4'd8},  // R8 agreeing writers
    '{2'd3, 1'b1, 8'h5A, 16'h8888, 32'h00002211, 4'd8},  // R8 disagreeing writers
    '{2'd2, 1'b0, 8'h01, 16'h0008, 32'h0,        4'd8},  // R8 readback
    '{2'd0, 1'b0, 8'hFF, 16'h3210, 32'hFFFFFFFF, 4'd2},  // R2 reserved code
    '{2'd0, 1'b0, 8'h55, 16'h3210, 32'h0,        4'd2},  // R2 unchanged words
    '{2'd0, 1'b0, 8'h06, 16'h0099, 32'h00000077, 4'd3},  // R3 same-step read
    '{2'd0, 1'b0, 8'h01, 16'h0009, 32'h0,        4'd3},  // R3 later read
    '{2'd3, 1'b1, 8'h00, 16'h1234, 32'h12345678, 4'd9},  // R9 idle
    '{2'd0, 1'b0, 8'h55, 16'h5893, 32'h0,        4'd10}  // R10 distinct reads
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       mode_i = '0;
  logic             wpol_i = 1'b0;
  logic [2*NP-1:0]  op_i = '0;
  logic [NP*AW-1:0] addr_i = '0;
  logic [NP*DW-1:0] wdata_i = '0;
  logic [NP*DW-1:0] rdata_o;
  logic [NP-1:0]    viol_o;

  int checks = 0, fails = 0;
  logic [DW-1:0] model [DEPTH];

  always #2 clk = ~clk;

  pram_mem_arbiter #(.NP(NP), .DEPTH(DEPTH), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .wpol_i(wpol_i), .op_i(op_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .viol_o(viol_o));

  task automatic check(input int tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run_step(input vec_t v);
    logic [DW-1:0] exp_rd [NP];
    logic [NP-1:0] exp_v;
    logic [DW-1:0] nmem [DEPTH];
    exp_v = '0;
    for (int e = 0; e < DEPTH; e++) nmem[e] = model[e];
    for (int p = 0; p < NP; p++) begin
      logic earlier;
      exp_rd[p] = '0;
      if (v.ops[2*p +: 2] == 2'b01) begin
        earlier = 1'b0;
        for (int q = 0; q < p; q++)
          if (v.ops[2*q +: 2] == 2'b01 && v.addrs[4*q +: 4] == v.addrs[4*p +: 4]) earlier = 1'b1;
        if (!v.mode[1] && earlier) exp_v[p] = 1'b1;
        else exp_rd[p] = model[v.addrs[4*p +: 4]];
      end
    end
    for (int a = 0; a < DEPTH; a++) begin
      int n, first_p;
      logic agree;
      logic [DW-1:0] first_d;
      n = 0; first_p = 0; agree = 1'b1; first_d = '0;
      for (int p = 0; p < NP; p++)
        if (v.ops[2*p +: 2] == 2'b10 && v.addrs[4*p +: 4] == 4'(a)) begin
          n++;
          if (n == 1) begin first_p = p; first_d = v.wd[8*p +: 8]; end
          else if (v.wd[8*p +: 8] != first_d) agree = 1'b0;
        end
      if (n > 0) begin
        if (!v.mode[0]) begin
          nmem[a] = first_d;
          for (int p = 0; p < NP; p++)
            if (p != first_p && v.ops[2*p +: 2] == 2'b10 && v.addrs[4*p +: 4] == 4'(a)) exp_v[p] = 1'b1;
        end else if (!v.pol || agree) begin
          nmem[a] = first_d;
        end else begin
          for (int p = 0; p < NP; p++)
            if (v.ops[2*p +: 2] == 2'b10 && v.addrs[4*p +: 4] == 4'(a)) exp_v[p] = 1'b1;
        end
      end
    end
    mode_i = v.mode; wpol_i = v.pol; op_i = v.ops; addr_i = v.addrs; wdata_i = v.wd;
    @(posedge clk);
    @(negedge clk);
    op_i = '0;
    for (int p = 0; p < NP; p++) begin
      check(v.tag, $sformatf("port%0d rdata", p), 32'(rdata_o[p*DW +: DW]), 32'(exp_rd[p]));
      check(v.tag, $sformatf("port%0d viol", p), 32'(viol_o[p]), 32'(exp_v[p]));
    end
    for (int e = 0; e < DEPTH; e++) model[e] = nmem[e];
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int e = 0; e < DEPTH; e++) model[e] = '0;
    repeat (3) @(negedge clk);
    check(1, "rdata after reset", 32'(rdata_o), 32'h0);   // R1
    check(1, "viol after reset", 32'(viol_o), 32'h0);     // R1
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < DEPTH / NP; k++) begin            // R1 sweep of all words
      vec_t s;
      s = '{2'd2, 1'b0, 8'h55, 16'(((4*k+3) << 12) | ((4*k+2) << 8) | ((4*k+1) << 4) | (4*k)), 32'h0, 4'd1};
      run_step(s);
    end
    for (int i = 0; i < NV; i++) run_step(VEC[i]);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule